// File: doc/BRIEF.md
# Five-channel output compare unit

This block watches an externally supplied free-running counter and raises a flag when the counter reaches a programmed value. It holds five compare registers, each 16 bits wide. Software loads each register one byte at a time over a small byte-wide register bus. Each time the counter advance strobe is high, every enabled channel compares its register with the counter value present that cycle. An equal compare sets that channel's flag bit.

All five channels share one enable byte and one flag byte. Channel 1 sits in the most significant bit and each later channel takes the next lower bit. Software clears flags by writing ones to them. The interrupt request is high whenever any flag is set while its enable is also set. The counter and the prescaler in front of it live outside this block. The block only sees the visible counter value and the strobe that marks each advance.

The register bus and the counter inputs are plain control pins with no handshake. Writes take effect at the clock edge where the write strobe is sampled high. Read data is a combinational function of the address. There is no back-pressure: the block accepts a write and a counter advance in every cycle.

Top module: `ocmp_unit`

## Requirements
- R1: After reset, every compare register reads 0xFFFF, and the enable byte, the flag byte and `irq` are all zero.
- R2: Address 2k holds the high byte and address 2k+1 the low byte of the compare register of channel k+1 (k = 0..4). Each byte reads back what was last written to it.
- R3: At a clock edge where `cnt_step` is 1, an enabled channel whose compare register equals `cnt_value` sets its flag bit. The flag reads as 1 from the cycle after that edge.
- R4: A channel whose enable bit is 0 never sets its flag. With enable bits 7..3 all zero, no flag is ever set.
- R5: An equal compare while `cnt_step` is 0 sets no flag.
- R6: The flag byte is at address 11. Writing a 1 to a flag bit clears it, and writing a 0 leaves it unchanged. If a clear and a new match for the same channel land at the same edge, the flag ends up set.
- R7: The enable byte is at address 10, with channel n at bit 8-n (channel 1 at bit 7, channel 5 at bit 3). Bits 2..0 of both the enable byte and the flag byte always read 0.
- R8: `irq` is 1 exactly when some channel has both its flag and its enable bit set. It follows enable writes in the cycle after the write edge.
- R9: A compare register write takes effect for counter advances after the write edge. An advance at the same edge as the write is compared against the old value.
- R10: Addresses 12 to 15 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cnt_value | input | 16 | Visible counter value |
| cnt_step | input | 1 | High in cycles where the counter has advanced to `cnt_value` |
| irq | output | 1 | Interrupt request: OR over channels of flag AND enable |

## Verification
The bench builds the block with its default parameters: five channels, 16-bit compare registers and a 4-bit address. This keeps the whole 16-bit counter range within reach. One sweep steps the counter through all 65536 values with a mix of enabled and disabled channels. Its flag byte and `irq` are checked against an arithmetic model on every step. Directed sequences cover the same-edge cases: a write coinciding with a count, a clear coinciding with a match, and equality without a strobe.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Channel index c (0-based) occupies bit 7-c of the enable and flag bytes.
  function automatic int unsigned chan_bit(input int unsigned c);
    return BYTE_W - 1 - c;
  endfunction
endpackage

// File: rtl/ocmp_chan.sv
module ocmp_chan
  import ocmp_pkg::*;
#(
  parameter int unsigned CMP_W  = 16,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BASE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  byte_t             bus_wdata,
  input  logic [CMP_W-1:0]  cnt_value,
  input  logic              cnt_step,
  input  logic              enable,
  output logic [CMP_W-1:0]  cmp_value,
  output logic              hit
);
  localparam int unsigned LANES = CMP_W / BYTE_W;

  byte_t lane_q [LANES];
  logic [LANES-1:0] lane_wr;
  logic wr_any;

  // Lane 0 is the most significant byte, at the lowest address.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_wr[l] = bus_wr && (bus_addr == ADDR_W'(BASE + l));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q[l] <= '1;
      else if (lane_wr[l]) lane_q[l] <= bus_wdata;
    end
    assign cmp_value[CMP_W-1-BYTE_W*l -: BYTE_W] = lane_q[l];
  end

  assign wr_any = |lane_wr;
  assign hit    = cnt_step && enable && (cmp_value == cnt_value);

  p_reset_cmp_r1: assert property (@(posedge clk) $rose(rst_n) |-> cmp_value == '1)
    else $error("compare register not all ones after reset");
  p_hold_cmp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_any) |-> $stable(cmp_value))
    else $error("compare register changed without a write");
endmodule

// File: rtl/ocmp_status.sv
module ocmp_status
  import ocmp_pkg::*;
#(
  parameter int unsigned NUM_CH   = 5,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned EN_ADDR  = 10,
  parameter int unsigned FLG_ADDR = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  byte_t             bus_wdata,
  input  logic [NUM_CH-1:0] hit_v,
  output logic [NUM_CH-1:0] en_q,
  output byte_t             en_byte,
  output byte_t             flag_byte,
  output logic              irq
);
  logic [NUM_CH-1:0] flag_q;
  logic [NUM_CH-1:0] clr_v;
  logic [NUM_CH-1:0] wr_en_v;
  logic en_wr, flg_wr;
  logic unused_wbits;

  assign en_wr  = bus_wr && (bus_addr == ADDR_W'(EN_ADDR));
  assign flg_wr = bus_wr && (bus_addr == ADDR_W'(FLG_ADDR));
  assign unused_wbits = ^bus_wdata;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_en_v[c] = bus_wdata[chan_bit(c)];
    assign clr_v[c]   = flg_wr && bus_wdata[chan_bit(c)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      if (en_wr) en_q <= wr_en_v;
      flag_q <= (flag_q & ~clr_v) | hit_v;   // new match beats a clear
    end
  end

  always_comb begin
    en_byte   = '0;
    flag_byte = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      en_byte[chan_bit(c)]   = en_q[c];
      flag_byte[chan_bit(c)] = flag_q[c];
    end
  end

  assign irq = |(flag_q & en_q);

  p_flag_from_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_q & ~$past(flag_q)) & ~$past(hit_v)) == '0)
    else $error("flag rose without a match");
  p_hit_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_v & ~en_q) == '0)
    else $error("match reported on a disabled channel");
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & $past(clr_v & ~hit_v)) == '0)
    else $error("flag survived a write-one clear");
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
  import ocmp_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CMP_W  = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [CMP_W-1:0]  cnt_value,
  input  logic              cnt_step,
  output logic              irq
);
  localparam int unsigned LANES    = CMP_W / BYTE_W;
  localparam int unsigned EN_ADDR  = NUM_CH * LANES;
  localparam int unsigned FLG_ADDR = EN_ADDR + 1;

  logic [CMP_W-1:0]  cmp_arr [NUM_CH];
  logic [NUM_CH-1:0] hit_v;
  logic [NUM_CH-1:0] en_q;
  byte_t en_byte, flag_byte;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    ocmp_chan #(.CMP_W(CMP_W), .ADDR_W(ADDR_W), .BASE(c * LANES)) chan_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .cnt_value(cnt_value), .cnt_step(cnt_step),
      .enable(en_q[c]), .cmp_value(cmp_arr[c]), .hit(hit_v[c]));
  end

  ocmp_status #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
                .EN_ADDR(EN_ADDR), .FLG_ADDR(FLG_ADDR)) status_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .hit_v(hit_v), .en_q(en_q),
    .en_byte(en_byte), .flag_byte(flag_byte), .irq(irq));

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int l = 0; l < LANES; l++)
        if (bus_addr == ADDR_W'(c * LANES + l))
          bus_rdata = cmp_arr[c][CMP_W-1-BYTE_W*l -: BYTE_W];
    if (bus_addr == ADDR_W'(EN_ADDR))  bus_rdata = en_byte;
    if (bus_addr == ADDR_W'(FLG_ADDR)) bus_rdata = flag_byte;
  end

  p_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(FLG_ADDR) || bus_addr == ADDR_W'(EN_ADDR))
      |-> bus_rdata[2:0] == 3'b000)
    else $error("reserved status bits read nonzero");
  p_irq_after_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(|hit_v) && !$past(bus_wr && bus_addr == ADDR_W'(EN_ADDR))) |-> irq)
    else $error("irq low after an enabled match");
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_W'(FLG_ADDR)) |-> bus_rdata == '0)
    else $error("unmapped address read nonzero");
endmodule

// File: tb/ocmp_unit_tb_top.sv
module ocmp_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int EN_A = 10;
  localparam int FLG_A = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [15:0] cnt_value = '0;
  logic cnt_step = 1'b0;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_value(cnt_value),
    .cnt_step(cnt_step), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    bus_addr = 4'(a);
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] sweep_cmp(input int c);
    return 16'(32'h1234 * (c + 1));
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic [7:0] exp_flags;
    logic [7:0] en_mask;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    for (int a = 0; a < 10; a++) begin rd(a, d); check("R1 cmp byte", d, 8'hFF); end
    rd(EN_A, d);  check("R1 enable byte", d, 8'h00);
    rd(FLG_A, d); check("R1 flag byte", d, 8'h00);
    check("R1 irq", irq, 1'b0);

    // R2: byte map readback
    for (int c = 0; c < 5; c++) begin
      wr(2*c,   8'(8'h10 + c));
      wr(2*c+1, 8'(8'h21 * (c + 1)));
    end
    for (int c = 0; c < 5; c++) begin
      rd(2*c, d);   check("R2 high byte", d, 8'(8'h10 + c));
      rd(2*c+1, d); check("R2 low byte", d, 8'(8'h21 * (c + 1)));
    end

    // R10: unmapped addresses
    for (int a = 12; a < 16; a++) wr(a, 8'h55);
    for (int a = 12; a < 16; a++) begin rd(a, d); check("R10 unmapped read", d, 8'h00); end
    rd(EN_A, d);  check("R10 enable untouched", d, 8'h00);
    rd(0, d);     check("R10 cmp untouched", d, 8'h10);

    // R7: enable byte layout, reserved bits
    wr(EN_A, 8'hFF);
    rd(EN_A, d); check("R7 enable bits 7..3 only", d, 8'hF8);

    // R3/R4/R8: full-range sweep, channels 1,3,5 enabled (bits 7,5,3)
    for (int c = 0; c < 5; c++) begin
      wr(2*c,   sweep_cmp(c)[15:8]);
      wr(2*c+1, sweep_cmp(c)[7:0]);
    end
    en_mask = 8'hA8;
    wr(EN_A, en_mask);
    wr(FLG_A, 8'hF8);
    bus_addr = 4'(FLG_A);
    exp_flags = 8'h00;
    @(negedge clk);
    cnt_step = 1'b1; cnt_value = 16'h0000;
    for (int v = 1; v <= 65536; v++) begin
      @(negedge clk);
      for (int c = 0; c < 5; c++)
        if (en_mask[7-c] && sweep_cmp(c) == 16'(v - 1)) exp_flags[7-c] = 1'b1;
      check("R3 R4 sweep flags", bus_rdata, exp_flags);
      check("R8 sweep irq", irq, |(exp_flags & en_mask));
      if (v < 65536) cnt_value = 16'(v);
    end
    cnt_step = 1'b0;
    check("R4 disabled channels clear", exp_flags, 8'hA8);

    // R4: no enables, part sweep through all compare values
    wr(EN_A, 8'h00);
    wr(FLG_A, 8'hF8);
    bus_addr = 4'(FLG_A);
    @(negedge clk);
    cnt_step = 1'b1;
    for (int v = 16'h1200; v < 16'h5C00; v++) begin
      cnt_value = 16'(v);
      @(negedge clk);
    end
    cnt_step = 1'b0;
    @(negedge clk);
    rd(FLG_A, d); check("R4 no enables no flags", d, 8'h00);

    // R5: equality without strobe
    wr(0, 8'h00); wr(1, 8'h50);
    wr(EN_A, 8'h80);
    @(negedge clk);
    cnt_value = 16'h0050; cnt_step = 1'b0;
    repeat (3) @(negedge clk);
    rd(FLG_A, d); check("R5 no strobe no flag", d, 8'h00);
    cnt_step = 1'b1;
    @(negedge clk);
    cnt_step = 1'b0;
    rd(FLG_A, d); check("R5 strobe sets flag", d, 8'h80);
    check("R8 irq with flag", irq, 1'b1);

    // R6: write-one clear, set wins
    wr(FLG_A, 8'h00); rd(FLG_A, d); check("R6 zero write keeps", d, 8'h80);
    wr(FLG_A, 8'h40); rd(FLG_A, d); check("R6 other bit keeps", d, 8'h80);
    wr(FLG_A, 8'h80); rd(FLG_A, d); check("R6 one clears", d, 8'h00);
    check("R6 irq after clear", irq, 1'b0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'(FLG_A); bus_wdata = 8'h80;
    cnt_value = 16'h0050; cnt_step = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; cnt_step = 1'b0;
    rd(FLG_A, d); check("R6 set beats clear", d, 8'h80);
    wr(FLG_A, 8'hF8);

    // R9: write and count at the same edge
    wr(2, 8'h00); wr(3, 8'h00);
    wr(EN_A, 8'h40);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 8'h77;
    cnt_value = 16'h0077; cnt_step = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(FLG_A, d); check("R9 same-edge write no match", d, 8'h00);
    @(negedge clk);
    cnt_step = 1'b0;
    rd(FLG_A, d); check("R9 next count matches", d, 8'h40);

    // R8: irq follows enables
    check("R8 irq set", irq, 1'b1);
    wr(EN_A, 8'h00);
    check("R8 irq off with enable off", irq, 1'b0);
    rd(FLG_A, d); check("R8 flag kept", d, 8'h40);
    wr(EN_A, 8'h40);
    check("R8 irq back on", irq, 1'b1);

    // R1: reset again clears everything
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(FLG_A, d); check("R1 flags after reset", d, 8'h00);
    rd(3, d);     check("R1 cmp after reset", d, 8'hFF);
    check("R1 irq after reset", irq, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule